// File: doc/BRIEF.md
# Cluster Core Reset Controller

This block is the register-mapped reset manager for a multi-cluster processor complex. Every cluster owns fourteen reset domains: a core, a vector unit and a core-debug domain for each of its four cores, plus a shared L2 domain and a shared cluster-debug domain. Software puts domains into reset by writing ones to a per-cluster request register, and takes them out by writing ones to a per-cluster release register. Zero bits leave their domains alone. A change reaches the domain outputs only after a settle delay, so software polls a per-cluster status word. The same word also reports each core's wait-for-interrupt, wait-for-event and debug-acknowledge pins.

A fabric-side mode register holds one snoop-filter enable bit per cluster. Its readback, and the enable outputs it drives, follow a write only after a short lag, so software rereads the register until it matches what was written. A separate invalidate register starts a snoop-filter invalidation with a one-cycle pulse. Access is through a 32-bit register port with a valid/ready handshake and a read response one cycle after the request.

Top module: `cluster_reset_ctrl`

## Requirements
- R1: After reset, cluster 0 has its core 0 core, vector and core-debug domains released, along with its L2 and cluster-debug domains (domain word 0x1CEE). Every other cluster reads 0x3FFF. snoopEnable is 1 (cluster 0 only), and snoopInvalidate and rspValid are low.
- R2: A write to the request register at 0x520 + 8*c sets the target reset state of every domain of cluster c whose data bit is 1. Domains whose data bit is 0 keep their state.
- R3: A write to the release register at 0x524 + 8*c clears the target reset state of every domain of cluster c whose data bit is 1. Domains whose data bit is 0 keep their state.
- R4: Domain word layout: bit x is core x, bit 4+x is vector unit x, bit 8 is L2, bit 9+x is core debug x, and bit 13 is cluster debug (x = 0..3). A 1 means the domain is held in reset. A target change reaches domainReset exactly SETTLE_CYCLES clock edges after the write edge, and not before.
- R5: A write to either control register of a cluster whose timer is still running restarts that cluster's timer. All pending changes of the cluster then appear together, SETTLE_CYCLES edges after the latest write.
- R6: A read of 0x1520 + 8*c returns the applied domain word in bits 13:0, WFI of core x in bit 16+x, WFE of core x in bit 20+x and the debug acknowledge of core x in bit 24+x. WFI and WFE read 0 while core x's core reset bit is 1. All other bits read 0.
- R7: A write to 0x0C sets the snoop-filter target, with bit c for cluster c. The readback of 0x0C and the snoopEnable output take the new value exactly SNOOP_LAG edges after the write edge.
- R8: A write to 0x10 with bit 8 set raises snoopInvalidate for exactly the one cycle after the write edge. A write to 0x10 with bit 8 clear gives no pulse. A read of 0x10 returns 0.
- R9: reqReady is always 1. rspValid is high for exactly the cycle after each accepted read and at no other time, and rspData is valid while it is high.
- R10: A read of any other offset, including the status offsets and the odd words between status registers, returns 0. A write to any such offset changes no domain and no snoop-filter bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Request accepted (always 1) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Byte offset of the register |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| coreWfi | input | NUM_CLUSTERS*4 | Per-core wait-for-interrupt, index 4*c+x |
| coreWfe | input | NUM_CLUSTERS*4 | Per-core wait-for-event, index 4*c+x |
| coreDbgAck | input | NUM_CLUSTERS*4 | Per-core debug acknowledge, index 4*c+x |
| domainReset | output | NUM_CLUSTERS*14 | Applied domain reset state, cluster c at bits 14*c +: 14 |
| snoopEnable | output | NUM_CLUSTERS | Applied snoop-filter enable per cluster |
| snoopInvalidate | output | 1 | One-cycle invalidate start pulse |

## Verification
The hardest case to reach is a settle-timer restart. A second write must land on a cluster while its first change is still pending, and the check must show that nothing moved at the first change's original deadline. The bench writes a release, waits half the settle period, writes a second release to the same cluster, and then samples domainReset one edge before and one edge after the second deadline. The status-word gating of WFI and WFE needs a cluster that has some cores released and some held. The bench therefore drives all activity pins high after a partial release, so that a missing gate shows up as extra bits.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int ADDR_W   = 13;
  localparam int DOM_W    = 14;
  localparam int CORES    = 4;
  localparam int IDX_W    = 4;
  localparam int STRIDE   = 8;
  localparam int INV_BIT  = 8;

  localparam logic [ADDR_W-1:0] OFF_REQ    = 13'h0520;
  localparam logic [ADDR_W-1:0] OFF_REL    = 13'h0524;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 13'h1520;
  localparam logic [ADDR_W-1:0] OFF_SFMODE = 13'h000C;
  localparam logic [ADDR_W-1:0] OFF_SFINV  = 13'h0010;

  localparam int L2_BIT    = 8;
  localparam int CLDBG_BIT = 13;
  localparam int VEC_BASE  = 4;
  localparam int CDBG_BASE = 9;
  localparam int WFI_BASE  = 16;
  localparam int WFE_BASE  = 20;
  localparam int ACK_BASE  = 24;

  typedef enum logic [1:0] {SEL_ZERO, SEL_STATUS, SEL_MODE} rdSelT;

  typedef struct packed {
    logic             setWr;
    logic             clrWr;
    logic             modeWr;
    logic             invWr;
    logic [IDX_W-1:0] wrIdx;
    rdSelT            rdSel;
    logic [IDX_W-1:0] rdIdx;
  } strobeT;

  // Power-on domain word: the boot core of cluster 0 and its shared domains run.
  function automatic logic [DOM_W-1:0] bootWord(int c);
    logic [DOM_W-1:0] keepRunning;
    keepRunning = '0;
    keepRunning[0] = 1'b1;
    keepRunning[VEC_BASE] = 1'b1;
    keepRunning[CDBG_BASE] = 1'b1;
    keepRunning[L2_BIT] = 1'b1;
    keepRunning[CLDBG_BIT] = 1'b1;
    return (c == 0) ? ~keepRunning : '1;
  endfunction
endpackage

// File: rtl/rstc_ctrl.sv
module rstc_ctrl
  import rstc_pkg::*;
#(
  parameter int NUM_CLUSTERS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              invBit,
  output logic              reqReady,
  output logic              rspValid,
  output strobeT            strobe
);
  logic             hitReq, hitRel, hitStat;
  logic [IDX_W-1:0] hitIdx;
  logic             hitMode, hitInv;
  logic             wrAcc, rdAcc;
  rdSelT            rdSelQ;
  logic [IDX_W-1:0] rdIdxQ;

  always_comb begin
    hitReq  = 1'b0;
    hitRel  = 1'b0;
    hitStat = 1'b0;
    hitIdx  = '0;
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      if (reqAddr == OFF_REQ + ADDR_W'(STRIDE * c)) begin
        hitReq = 1'b1;
        hitIdx = IDX_W'(c);
      end
      if (reqAddr == OFF_REL + ADDR_W'(STRIDE * c)) begin
        hitRel = 1'b1;
        hitIdx = IDX_W'(c);
      end
      if (reqAddr == OFF_STAT + ADDR_W'(STRIDE * c)) begin
        hitStat = 1'b1;
        hitIdx  = IDX_W'(c);
      end
    end
  end

  assign hitMode  = (reqAddr == OFF_SFMODE);
  assign hitInv   = (reqAddr == OFF_SFINV);
  assign reqReady = 1'b1;
  assign wrAcc    = reqValid && reqReady && reqWrite;
  assign rdAcc    = reqValid && reqReady && !reqWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rdSelQ   <= SEL_ZERO;
      rdIdxQ   <= '0;
    end else begin
      rspValid <= rdAcc;
      if (rdAcc) begin
        rdIdxQ <= hitIdx;
        if (hitStat)      rdSelQ <= SEL_STATUS;
        else if (hitMode) rdSelQ <= SEL_MODE;
        else              rdSelQ <= SEL_ZERO;
      end
    end
  end

  always_comb begin
    strobe.setWr  = wrAcc && hitReq;
    strobe.clrWr  = wrAcc && hitRel;
    strobe.modeWr = wrAcc && hitMode;
    strobe.invWr  = wrAcc && hitInv && invBit;
    strobe.wrIdx  = hitIdx;
    strobe.rdSel  = rdSelQ;
    strobe.rdIdx  = rdIdxQ;
  end
endmodule

// File: rtl/rstc_dpath.sv
module rstc_dpath
  import rstc_pkg::*;
#(
  parameter int NUM_CLUSTERS  = 4,
  parameter int SETTLE_CYCLES = 16,
  parameter int SNOOP_LAG     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strobe,
  input  logic [DOM_W-1:0]              wdata,
  input  logic [NUM_CLUSTERS*CORES-1:0] coreWfi,
  input  logic [NUM_CLUSTERS*CORES-1:0] coreWfe,
  input  logic [NUM_CLUSTERS*CORES-1:0] coreDbgAck,
  output logic [NUM_CLUSTERS*DOM_W-1:0] domainReset,
  output logic [NUM_CLUSTERS-1:0]       snoopEnable,
  output logic                          snoopInvalidate,
  output logic [31:0]                   rdData
);
  localparam int SC_W = $clog2(SETTLE_CYCLES + 1);
  localparam int SL_W = $clog2(SNOOP_LAG + 1);

  logic [31:0] statWord [NUM_CLUSTERS];

  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : gCluster
    logic [DOM_W-1:0] tgtDom, curDom;
    logic [SC_W-1:0]  settleCnt;
    logic             wrHere;
    logic [CORES-1:0] coreRun;

    assign wrHere = (strobe.setWr || strobe.clrWr) && (strobe.wrIdx == IDX_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tgtDom    <= bootWord(c);
        curDom    <= bootWord(c);
        settleCnt <= '0;
      end else if (wrHere) begin
        tgtDom    <= strobe.setWr ? (tgtDom | wdata) : (tgtDom & ~wdata);
        settleCnt <= SC_W'(SETTLE_CYCLES);
      end else if (settleCnt == SC_W'(1)) begin
        curDom    <= tgtDom;
        settleCnt <= '0;
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - 1'b1;
      end
    end

    assign coreRun = ~curDom[CORES-1:0];
    assign domainReset[c*DOM_W +: DOM_W] = curDom;

    always_comb begin
      statWord[c] = '0;
      statWord[c][DOM_W-1:0] = curDom;
      statWord[c][WFI_BASE +: CORES] = coreWfi[c*CORES +: CORES] & coreRun;
      statWord[c][WFE_BASE +: CORES] = coreWfe[c*CORES +: CORES] & coreRun;
      statWord[c][ACK_BASE +: CORES] = coreDbgAck[c*CORES +: CORES];
    end
  end

  logic [NUM_CLUSTERS-1:0] sfTgt, sfCur;
  logic [SL_W-1:0]         sfCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sfTgt <= NUM_CLUSTERS'(1);
      sfCur <= NUM_CLUSTERS'(1);
      sfCnt <= '0;
    end else if (strobe.modeWr) begin
      sfTgt <= wdata[NUM_CLUSTERS-1:0];
      sfCnt <= SL_W'(SNOOP_LAG);
    end else if (sfCnt == SL_W'(1)) begin
      sfCur <= sfTgt;
      sfCnt <= '0;
    end else if (sfCnt != '0) begin
      sfCnt <= sfCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snoopInvalidate <= 1'b0;
    else       snoopInvalidate <= strobe.invWr;
  end

  assign snoopEnable = sfCur;

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_STATUS: begin
        for (int c = 0; c < NUM_CLUSTERS; c++)
          if (strobe.rdIdx == IDX_W'(c)) rdData = statWord[c];
      end
      SEL_MODE: rdData = 32'(sfCur);
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/cluster_reset_ctrl.sv
module cluster_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int NUM_CLUSTERS  = 4,
  parameter int SETTLE_CYCLES = 16,
  parameter int SNOOP_LAG     = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [12:0]                   reqAddr,
  input  logic [31:0]                   reqWdata,
  output logic                          rspValid,
  output logic [31:0]                   rspData,
  input  logic [NUM_CLUSTERS*4-1:0]     coreWfi,
  input  logic [NUM_CLUSTERS*4-1:0]     coreWfe,
  input  logic [NUM_CLUSTERS*4-1:0]     coreDbgAck,
  output logic [NUM_CLUSTERS*14-1:0]    domainReset,
  output logic [NUM_CLUSTERS-1:0]       snoopEnable,
  output logic                          snoopInvalidate
);
  strobeT strobe;

  rstc_ctrl #(.NUM_CLUSTERS(NUM_CLUSTERS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .invBit   (reqWdata[INV_BIT]),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  rstc_dpath #(
    .NUM_CLUSTERS  (NUM_CLUSTERS),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .SNOOP_LAG     (SNOOP_LAG)
  ) uDpath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .wdata           (reqWdata[DOM_W-1:0]),
    .coreWfi         (coreWfi),
    .coreWfe         (coreWfe),
    .coreDbgAck      (coreDbgAck),
    .domainReset     (domainReset),
    .snoopEnable     (snoopEnable),
    .snoopInvalidate (snoopInvalidate),
    .rdData          (rspData)
  );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
  import rstc_pkg::*;
#(
  parameter int NUM_CLUSTERS  = 4,
  parameter int SETTLE_CYCLES = 16,
  parameter int SNOOP_LAG     = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqWrite,
  input logic [12:0]                reqAddr,
  input logic [31:0]                reqWdata,
  input logic                       rspValid,
  input logic [31:0]                rspData,
  input logic [NUM_CLUSTERS*14-1:0] domainReset,
  input logic [NUM_CLUSTERS-1:0]    snoopEnable,
  input logic                       snoopInvalidate
);
  logic rdReq, isStatAddr, isMapped;

  always_comb begin
    isStatAddr = 1'b0;
    isMapped   = (reqAddr == OFF_SFMODE) || (reqAddr == OFF_SFINV);
    for (int c = 0; c < NUM_CLUSTERS; c++) begin
      if (reqAddr == OFF_STAT + 13'(STRIDE * c)) isStatAddr = 1'b1;
      if (reqAddr == OFF_REQ + 13'(STRIDE * c) || reqAddr == OFF_REL + 13'(STRIDE * c))
        isMapped = 1'b1;
    end
    isMapped = isMapped || isStatAddr;
  end

  assign rdReq = reqValid && !reqWrite;

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rspValid); // R9
  AST_RESPONSE_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(rdReq)); // R9
  AST_INVALIDATE_CAUSED: assert property (@(posedge clk) disable iff (!rstN)
    snoopInvalidate |-> $past(reqValid && reqWrite && reqAddr == OFF_SFINV && reqWdata[INV_BIT])); // R8
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(!isMapped)) |-> (rspData == 32'h0)); // R10
  AST_ACTIVITY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(isStatAddr)) |->
      ((rspData[WFI_BASE +: 4] & rspData[3:0]) == 4'h0 &&
       (rspData[WFE_BASE +: 4] & rspData[3:0]) == 4'h0)); // R6

  if (SNOOP_LAG > 1) begin : gSnoopHold
    AST_SNOOP_LAGS: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && reqWrite && reqAddr == OFF_SFMODE) |=> $stable(snoopEnable)); // R7
  end

  if (SETTLE_CYCLES > 1) begin : gSettleHold
    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : gCl
      AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (reqValid && reqWrite && (reqAddr == OFF_REQ + 13'(STRIDE * c) ||
                                  reqAddr == OFF_REL + 13'(STRIDE * c)))
        |=> $stable(domainReset[c*14 +: 14])); // R4
    end
  end
endmodule

bind cluster_reset_ctrl rstc_checker #(
  .NUM_CLUSTERS  (NUM_CLUSTERS),
  .SETTLE_CYCLES (SETTLE_CYCLES),
  .SNOOP_LAG     (SNOOP_LAG)
) uChk (
  .clk             (clk),
  .rstN            (rstN),
  .reqValid        (reqValid),
  .reqWrite        (reqWrite),
  .reqAddr         (reqAddr),
  .reqWdata        (reqWdata),
  .rspValid        (rspValid),
  .rspData         (rspData),
  .domainReset     (domainReset),
  .snoopEnable     (snoopEnable),
  .snoopInvalidate (snoopInvalidate)
);

// File: tb/tb_cluster_reset_ctrl.sv
module tb_cluster_reset_ctrl;
  localparam int NC     = 4;
  localparam int SETTLE = 16;
  localparam int LAG    = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic            reqWrite = 1'b0;
  logic [12:0]     reqAddr = '0;
  logic [31:0]     reqWdata = '0;
  logic            rspValid;
  logic [31:0]     rspData;
  logic [NC*4-1:0] coreWfi = '0;
  logic [NC*4-1:0] coreWfe = '0;
  logic [NC*4-1:0] coreDbgAck = '0;
  logic [NC*14-1:0] domainReset;
  logic [NC-1:0]   snoopEnable;
  logic            snoopInvalidate;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;
  logic [13:0] expDom [NC];

  always #4 clk = ~clk;

  cluster_reset_ctrl #(.NUM_CLUSTERS(NC), .SETTLE_CYCLES(SETTLE), .SNOOP_LAG(LAG)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .coreWfi(coreWfi), .coreWfe(coreWfe), .coreDbgAck(coreDbgAck),
    .domainReset(domainReset), .snoopEnable(snoopEnable), .snoopInvalidate(snoopInvalidate)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [12:0] a, output logic [31:0] d, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid === 1'b1, "R9 rspValid after read", 32'(rspValid), 32'h1);
    d = rspData;
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [13:0] domOf(int c);
    return domainReset[c*14 +: 14];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    expDom[0] = 14'h1CEE;
    for (int c = 1; c < NC; c++) expDom[c] = 14'h3FFF;
    for (int c = 0; c < NC; c++)
      check(domOf(c) === expDom[c], "R1 reset domain word", 32'(domOf(c)), 32'(expDom[c]));
    check(snoopEnable === 4'h1, "R1 snoop reset", 32'(snoopEnable), 32'h1);
    check(snoopInvalidate === 1'b0 && rspValid === 1'b0, "R1 idle outputs",
          32'({snoopInvalidate, rspValid}), 32'h0);
    check(reqReady === 1'b1, "R9 ready high", 32'(reqReady), 32'h1);
    busRead(13'h1520, d, "R6");
    check(d === 32'h0000_1CEE, "R6 status cluster0 at reset", d, 32'h0000_1CEE);
  endtask

  task automatic t_release_timing;
    // cluster 1: release core 2 (bits 2, 6, 11), L2 (bit 8), cluster debug (bit 13)
    busWrite(13'h052C, 32'h0000_2944);
    waitEdges(SETTLE - 1);
    check(domOf(1) === 14'h3FFF, "R4 no change before settle", 32'(domOf(1)), 32'h3FFF);
    waitEdges(1);
    expDom[1] = 14'h3FFF & ~14'h2944;
    check(domOf(1) === expDom[1], "R3 release applied at settle", 32'(domOf(1)), 32'(expDom[1]));
  endtask

  task automatic t_request;
    busWrite(13'h0520, 32'h0000_0001);
    waitEdges(SETTLE);
    check(domOf(0) === 14'h1CEF, "R2 request asserts only core0", 32'(domOf(0)), 32'h1CEF);
    busWrite(13'h0524, 32'h0000_0001);
    waitEdges(SETTLE);
    check(domOf(0) === 14'h1CEE, "R3 release restores core0", 32'(domOf(0)), 32'h1CEE);
  endtask

  task automatic t_restart;
    busWrite(13'h0534, 32'h0000_0001);
    waitEdges(SETTLE / 2);
    busWrite(13'h0534, 32'h0000_0010);
    waitEdges(SETTLE - 1);
    check(domOf(2) === 14'h3FFF, "R5 timer restarted", 32'(domOf(2)), 32'h3FFF);
    waitEdges(1);
    expDom[2] = 14'h3FEE;
    check(domOf(2) === expDom[2], "R5 both changes together", 32'(domOf(2)), 32'(expDom[2]));
  endtask

  task automatic t_status_gating;
    logic [31:0] d;
    coreWfi = '1; coreWfe = '1; coreDbgAck = '1;
    busRead(13'h1528, d, "R6");
    check(d === 32'h0F44_16BB, "R6 status gating cluster1", d, 32'h0F44_16BB);
    coreWfi = '0; coreWfe = '0; coreDbgAck = '0;
    busRead(13'h1528, d, "R6");
    check(d === 32'h0000_16BB, "R6 status idle pins", d, 32'h0000_16BB);
  endtask

  task automatic t_snoop;
    logic [31:0] d;
    busWrite(13'h000C, 32'h0000_000A);
    busRead(13'h000C, d, "R7");
    check(d === 32'h1, "R7 readback still old", d, 32'h1);
    waitEdges(LAG - 3);
    check(snoopEnable === 4'h1, "R7 enable before lag", 32'(snoopEnable), 32'h1);
    waitEdges(1);
    check(snoopEnable === 4'hA, "R7 enable at lag", 32'(snoopEnable), 32'hA);
    busRead(13'h000C, d, "R7");
    check(d === 32'hA, "R7 readback converged", d, 32'hA);
  endtask

  task automatic t_invalidate;
    logic [31:0] d;
    busWrite(13'h0010, 32'h0000_0100);
    check(snoopInvalidate === 1'b1, "R8 pulse high", 32'(snoopInvalidate), 32'h1);
    @(negedge clk);
    check(snoopInvalidate === 1'b0, "R8 pulse one cycle", 32'(snoopInvalidate), 32'h0);
    busWrite(13'h0010, 32'h0000_00FF);
    check(snoopInvalidate === 1'b0, "R8 no pulse without bit8", 32'(snoopInvalidate), 32'h0);
    busRead(13'h0010, d, "R8");
    check(d === 32'h0, "R8 reads zero", d, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    busWrite(13'h0540, 32'hFFFF_FFFF);
    busWrite(13'h1530, 32'hFFFF_FFFF);
    busWrite(13'h0528 + 13'h20, 32'hFFFF_FFFF);
    waitEdges(SETTLE + 2);
    for (int c = 0; c < NC; c++)
      check(domOf(c) === expDom[c], "R10 writes ignored", 32'(domOf(c)), 32'(expDom[c]));
    check(snoopEnable === 4'hA, "R10 snoop untouched", 32'(snoopEnable), 32'hA);
    busRead(13'h0540, d, "R10");
    check(d === 32'h0, "R10 unmapped read", d, 32'h0);
    busRead(13'h1524, d, "R10");
    check(d === 32'h0, "R10 gap between status words", d, 32'h0);
    @(negedge clk);
    check(rspValid === 1'b0, "R9 no response when idle", 32'(rspValid), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_release_timing();
    t_request();
    t_restart();
    t_status_gating();
    t_snoop();
    t_invalidate();
    t_unmapped();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule